// File: doc/BRIEF.md
# Three-Phase Gate Output Stage with Filtered Shutdown

This block is the last stage before the gate drivers of a three-phase inverter. It takes six raw PWM levels, one high-side and one low-side for each of phases U, V and W. It retimes them through a fixed two-register pipeline and applies a per-output polarity setting. It can also force all six outputs to their inactive level. Bit order on the six-bit buses is [0]=U high, [1]=U low, [2]=V high, [3]=V low, [4]=W high, [5]=W low.

Two asynchronous fault sources can force the outputs inactive. The first is an active-low shutdown input. It passes a two-flop synchronizer and then a pulse-width qualifier with a programmable length, so that glitches are rejected. The second is an optional active-high over-current trip input, qualified over a short fixed length. A qualified fault sets a latched flag, one per source. While either flag is set, every output sits at the de-asserted level of its configured polarity. A flag clears only on a clear pulse, and only once its source has gone back to the idle state.

All control pins are plain levels sampled every clock. The block has no stream interface, so no back-pressure rules apply.

Top module: `gate_kill_stage`

## Requirements
- R1: During and right after reset, `gate_out` equals the `INIT_LEVEL` parameter (default all zero) and `fault` is 2'b00.
- R2: With no fault latched, a value applied on `pwm_raw` appears on `gate_out` after exactly two rising clock edges.
- R3: Each output is `pwm_raw[i] XOR pol_low[i]`. A `pol_low` bit of 1 makes that output active-low; 0 (the natural default) makes it active-high.
- R4: The shutdown input is accepted only after it has been seen low for L consecutive synchronized samples, where L is the effective qualification length taken from `filt_len`. A low pulse lasting L-1 clocks sets no fault.
- R5: When `kill_n` goes low and stays low for L clocks, `fault[0]` rises after L+2 rising edges and all outputs are inactive after L+3 edges. With the largest L of 97, this is no more than 100 clocks.
- R6: While any fault bit is set, `gate_out[i]` equals `pol_low[i]`, which is the inactive level. Changes on `pwm_raw` have no effect, and a change of `pol_low` moves the forced level one edge later.
- R7: `fault_clr` clears `fault[0]` only if the synchronized `kill_n` is high. It clears `fault[1]` only if the synchronized trip is low or `trip_en` is 0. After a clear, the outputs follow `pwm_raw` again from the next edge.
- R8: A `filt_len` below 32 is treated as 32.
- R9: The qualification count restarts whenever the synchronized shutdown input returns high. Two low runs, each shorter than L and split by one high sample, set no fault.
- R10: With `trip_en`=1, a `trip` high for `TRIP_LEN` (default 4) consecutive clocks sets `fault[1]` after `TRIP_LEN`+2 rising edges. With `trip_en`=0, `trip` has no effect.
- R11: A `filt_len` above 97 is treated as 97.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_raw | input | 6 | Raw gate levels, bit order as above |
| pol_low | input | 6 | Per-output polarity, 1 = active-low |
| filt_len | input | 7 | Requested shutdown qualification length in clocks |
| kill_n | input | 1 | Asynchronous active-low shutdown request |
| trip | input | 1 | Asynchronous active-high over-current trip |
| trip_en | input | 1 | Enables the trip source |
| fault_clr | input | 1 | Clear request for the latched fault flags |
| gate_out | output | 6 | Gate outputs after polarity and shutdown forcing |
| fault | output | 2 | Latched fault flags: [0] shutdown, [1] trip |

## Verification
The pass-through path is driven with several distinct six-bit patterns under two polarity settings. This separates a wrong pipeline depth, a swapped bit order and a missing or misplaced XOR. Shutdown pulses of exactly L-1 and L clocks are tried at three programmed lengths: one at the minimum, one inside the range and one below the clamp, plus a check of the upper clamp. These show whether the count boundary is off by one and whether the clamps are honoured. A split low run distinguishes a restarting counter from an accumulating one. The clear tests issue the clear request both while the source is still active and after it has returned idle. The trip tests run with the enable off and on, which shows whether the flags are gated on the source state and whether the trip source is gated by its enable.

// File: rtl/gate_kill_pkg.sv
package gate_kill_pkg;
  localparam int NUM_GATES = 6;

  function automatic int clamp_len(input int req, input int lo, input int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction
endpackage

// File: rtl/gks_sync.sv
module gks_sync #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gks_qual_filter.sv
module gks_qual_filter #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic [CW-1:0] thr,
  output logic          hit
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = thr - 1'b1;
  assign hit = act && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!act)       cnt <= '0;
    else if (cnt < lim)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/gks_gate_bit.sv
module gks_gate_bit #(
  parameter bit INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic pol,
  input  logic block,
  output logic q
);
  logic stage;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= 1'b0;
      q     <= INIT;
    end else begin
      stage <= raw;
      q     <= block ? pol : (stage ^ pol);
    end
  end

  // R6: a blocked output lands on the inactive level of its polarity
  a_r6_forced_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    block |=> (q == $past(pol)));
endmodule

// File: rtl/gate_kill_stage.sv
module gate_kill_stage #(
  parameter int       FILT_W     = 7,
  parameter int       MIN_LEN    = 32,
  parameter int       MAX_LEN    = 97,
  parameter int       TRIP_LEN   = 4,
  parameter bit [5:0] INIT_LEVEL = 6'b000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        pwm_raw,
  input  logic [5:0]        pol_low,
  input  logic [FILT_W-1:0] filt_len,
  input  logic              kill_n,
  input  logic              trip,
  input  logic              trip_en,
  input  logic              fault_clr,
  output logic [5:0]        gate_out,
  output logic [1:0]        fault
);
  import gate_kill_pkg::*;

  localparam int CW  = $clog2(MAX_LEN + 1);
  localparam int TCW = $clog2(TRIP_LEN + 1);

  logic          kill_sync;
  logic          trip_sync;
  logic [CW-1:0] thr_eff;
  logic          kill_hit;
  logic          trip_hit;
  logic          trip_act;
  logic [1:0]    fault_q;
  logic          blocked;

  assign thr_eff  = CW'(clamp_len(int'(filt_len), MIN_LEN, MAX_LEN));
  assign trip_act = trip_sync && trip_en;

  gks_sync #(.RST_VAL(1'b1)) u_kill_sync (
    .clk(clk), .rst_n(rst_n), .d(kill_n), .q(kill_sync));

  gks_sync #(.RST_VAL(1'b0)) u_trip_sync (
    .clk(clk), .rst_n(rst_n), .d(trip), .q(trip_sync));

  gks_qual_filter #(.CW(CW)) u_kill_filt (
    .clk(clk), .rst_n(rst_n), .act(!kill_sync), .thr(thr_eff), .hit(kill_hit));

  gks_qual_filter #(.CW(TCW)) u_trip_filt (
    .clk(clk), .rst_n(rst_n), .act(trip_act), .thr(TCW'(TRIP_LEN)), .hit(trip_hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= 2'b00;
    end else begin
      if (kill_hit)                      fault_q[0] <= 1'b1;
      else if (fault_clr && kill_sync)   fault_q[0] <= 1'b0;
      if (trip_hit)                      fault_q[1] <= 1'b1;
      else if (fault_clr && !trip_act)   fault_q[1] <= 1'b0;
    end
  end

  assign blocked = |fault_q;
  assign fault   = fault_q;

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    gks_gate_bit #(.INIT(INIT_LEVEL[g])) u_bit (
      .clk(clk), .rst_n(rst_n), .raw(pwm_raw[g]), .pol(pol_low[g]),
      .block(blocked), .q(gate_out[g]));
  end

  // Assertion support: run length of low synchronized shutdown samples and pipeline warm-up
  logic [CW-1:0] low_run;
  logic [1:0]    warm;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run <= '0;
      warm    <= 2'b00;
    end else begin
      low_run <= kill_sync ? '0 : ((low_run == '1) ? low_run : low_run + 1'b1);
      warm    <= {warm[0], 1'b1};
    end
  end

  // R4 / R9: shutdown fault rises only after a long enough unbroken low run
  a_r4_qualified_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q[0]) |-> ($past(low_run) >= $past(thr_eff) - 1'b1));

  // R2 / R3: two-stage path with polarity applied
  a_r2_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (warm[1] && !blocked) |=> (gate_out == ($past(pwm_raw, 2) ^ $past(pol_low))));

  // R7: shutdown flag holds while the synchronized input is still low
  a_r7_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q[0] && !kill_sync) |=> fault_q[0]);

  // R10: trip flag never rises while the trip source is disabled
  a_r10_trip_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q[1]) |-> $past(trip_en));
endmodule

// File: tb/gate_kill_stage_tb.sv
module gate_kill_stage_tb;
  localparam int TRIP_LEN = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] pwm_raw;
  logic [5:0] pol_low;
  logic [6:0] filt_len;
  logic       kill_n;
  logic       trip;
  logic       trip_en;
  logic       fault_clr;
  logic [5:0] gate_out;
  logic [1:0] fault;

  int checks   = 0;
  int failures = 0;

  always #4 clk = ~clk;

  gate_kill_stage u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_raw(pwm_raw), .pol_low(pol_low),
    .filt_len(filt_len), .kill_n(kill_n), .trip(trip), .trip_en(trip_en),
    .fault_clr(fault_clr), .gate_out(gate_out), .fault(fault));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // clear after sources idle, and let outputs resume
  task automatic recover();
    kill_n = 1'b1; trip = 1'b0;
    tick(4);
    fault_clr = 1'b1; tick(1); fault_clr = 1'b0;
    tick(1);
  endtask

  task automatic t_reset();
    chk("R1 reset gate_out", {2'b0, gate_out}, 8'h00);
    chk("R1 reset fault", {6'b0, fault}, 8'h00);
  endtask

  task automatic t_pass(input logic [5:0] pol);
    logic [5:0] pats [4] = '{6'b000001, 6'b101010, 6'b110011, 6'b011110};
    pol_low = pol;
    pwm_raw = 6'b000000;
    tick(3);
    foreach (pats[i]) begin
      pwm_raw = pats[i];
      tick(1);
      chk("R2 one edge keeps old", {2'b0, gate_out}, {2'b0, pats[(i+3)%4] & {6{i != 0}} ^ pol});
      tick(1);
      chk("R3 two edges pattern^pol", {2'b0, gate_out}, {2'b0, pats[i] ^ pol});
    end
  endtask

  task automatic t_kill(input int req, input int eff, input logic [5:0] pol, input logic [5:0] raw);
    pol_low = pol; pwm_raw = raw; filt_len = 7'(req);
    tick(3);
    // pulse one short of the length
    kill_n = 1'b0; tick(eff - 1); kill_n = 1'b1;
    tick(4);
    chk("R4 short pulse rejected", {6'b0, fault}, 8'h00);
    chk("R4 outputs unaffected", {2'b0, gate_out}, {2'b0, raw ^ pol});
    tick(2);
    kill_n = 1'b0; tick(eff); kill_n = 1'b1;
    tick(1);
    chk("R5 no fault at L+1", {6'b0, fault}, 8'h00);
    tick(1);
    chk("R5 fault at L+2", {6'b0, fault}, 8'h01);
    chk("R5 outputs live at L+2", {2'b0, gate_out}, {2'b0, raw ^ pol});
    tick(1);
    chk("R5 outputs inactive at L+3", {2'b0, gate_out}, {2'b0, pol});
    recover();
    chk("R7 cleared", {6'b0, fault}, 8'h00);
    chk("R7 outputs resume", {2'b0, gate_out}, {2'b0, raw ^ pol});
  endtask

  task automatic t_fault_hold();
    pol_low = 6'b100101; pwm_raw = 6'b111111; filt_len = 7'd32;
    tick(3);
    kill_n = 1'b0; tick(35);
    chk("R6 inactive level per polarity", {2'b0, gate_out}, 8'h25);
    pwm_raw = 6'b010101; tick(3);
    chk("R6 raw ignored in fault", {2'b0, gate_out}, 8'h25);
    pol_low = 6'b011000; tick(1);
    chk("R6 polarity change moves forced level", {2'b0, gate_out}, 8'h18);
    fault_clr = 1'b1; tick(1); fault_clr = 1'b0;
    chk("R7 clear ignored while kill low", {6'b0, fault}, 8'h01);
    chk("R7 outputs still inactive", {2'b0, gate_out}, 8'h18);
    recover();
    chk("R7 cleared after kill high", {6'b0, fault}, 8'h00);
    chk("R7 resume after clear", {2'b0, gate_out}, {2'b0, 6'b010101 ^ 6'b011000});
  endtask

  task automatic t_split();
    pol_low = 6'b0; pwm_raw = 6'b001100; filt_len = 7'd32;
    tick(3);
    kill_n = 1'b0; tick(20); kill_n = 1'b1; tick(1);
    kill_n = 1'b0; tick(20); kill_n = 1'b1;
    tick(4);
    chk("R9 split run rejected", {6'b0, fault}, 8'h00);
  endtask

  task automatic t_max();
    pol_low = 6'b0; pwm_raw = 6'b000011; filt_len = 7'd120;
    tick(3);
    kill_n = 1'b0; tick(97); kill_n = 1'b1;
    tick(2);
    chk("R11 clamp at 97 accepts 97", {6'b0, fault}, 8'h01);
    tick(1);
    chk("R11 outputs inactive within 100", {2'b0, gate_out}, 8'h00);
    recover();
  endtask

  task automatic t_trip();
    pol_low = 6'b000111; pwm_raw = 6'b110000;
    tick(3);
    trip_en = 1'b0; trip = 1'b1; tick(10);
    chk("R10 trip disabled no fault", {6'b0, fault}, 8'h00);
    chk("R10 trip disabled outputs live", {2'b0, gate_out}, {2'b0, 6'b110111});
    trip = 1'b0; tick(3);
    trip_en = 1'b1; tick(1);
    trip = 1'b1; tick(TRIP_LEN + 1);
    chk("R10 no trip fault at N+1", {6'b0, fault}, 8'h00);
    tick(1);
    chk("R10 trip fault at N+2", {6'b0, fault}, 8'h02);
    tick(1);
    chk("R10 trip forces inactive", {2'b0, gate_out}, 8'h07);
    fault_clr = 1'b1; tick(1); fault_clr = 1'b0;
    chk("R7 trip clear ignored while high", {6'b0, fault}, 8'h02);
    recover();
    chk("R7 trip cleared", {6'b0, fault}, 8'h00);
    chk("R7 trip outputs resume", {2'b0, gate_out}, 8'h37);
  endtask

  initial begin
    rst_n = 1'b0; pwm_raw = '0; pol_low = '0; filt_len = 7'd32;
    kill_n = 1'b1; trip = 1'b0; trip_en = 1'b0; fault_clr = 1'b0;
    tick(4);
    t_reset();
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_pass(6'b000000);
    t_pass(6'b101010);
    t_kill(32, 32, 6'b000000, 6'b010110);    // R4 minimum length
    t_kill(40, 40, 6'b110100, 6'b011011);    // R4 programmed length
    t_kill(5, 32, 6'b001001, 6'b100001);     // R8 below minimum
    t_fault_hold();
    t_split();
    t_max();
    t_trip();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule